// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's execute stage. Each cycle it looks at a pending exception code, an external interrupt request, and the core's current status register, PC, R15, vector base, delay-slot flag and sleep flag. From these it decides whether an event is taken. A pending exception always wins over an interrupt. When the block bit is set, an exception turns into a reset request unless it is the single exempt code.

When an event is taken, the block latches the saved copies of SR, PC and R15 and the new SR. It also latches the event code into the exception register or the interrupt register, and the new PC. It then pulses `taken_o` for one clock. The core loads the new state from these outputs and treats `taken_o` as an order to cancel any load-linked reservation and to leave sleep. The interrupt controller receives the current 4-bit mask and answers with a vector and a valid flag. The block does not model that controller's priority logic.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both high in the same cycle, the exception is taken. `evt_irq_o` reads 0, `expevt_o` gets the exception code and `intevt_o` keeps its previous value.
- R2: If SR bit 28 (block bit) is set and `exc_valid_i` is high with a code other than 0x1E0, `reset_req_o` pulses for one cycle. `taken_o` stays low, and `new_pc_o`, `sr_o` and `expevt_o` keep their previous values.
- R3: With the block bit set, exception code 0x1E0 is taken as a normal exception.
- R4: With the block bit set, an interrupt is ignored while `sleep_i` is low and taken while `sleep_i` is high.
- R5: `imask_o` equals SR bits 7:4. An interrupt is taken only when `irq_vec_valid_i` is high. Otherwise no event occurs and all held outputs are unchanged.
- R6: No interrupt is accepted while `dslot_i` is high.
- R7: On any taken event, `ssr_o` gets SR, `sgr_o` gets R15, and `sr_o` gets SR with bits 30 (privileged mode), 29 (register bank) and 28 (block) set. All other SR bits pass through unchanged unless R9 applies.
- R8: An event taken while `dslot_i` is high saves PC minus 2 in `spc_o` and pulses `dslot_clr_o`. Without a delay slot, `spc_o` gets PC and `dslot_clr_o` stays low.
- R9: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15 (FPU disable), set SR bits 7:4 to 0xF and set `new_pc_o` to 0xA0000000.
- R10: Exception codes 0x040 and 0x060 set `new_pc_o` to VBR+0x400.
- R11: All other exception codes set `new_pc_o` to VBR+0x100. For code 0x160, `spc_o` is PC plus 2.
- R12: A taken interrupt writes its vector to `intevt_o`, sets `evt_irq_o`, leaves `expevt_o` unchanged and sets `new_pc_o` to VBR+0x600.
- R13: All outputs are registered. They change at the first rising clock edge that samples the inputs. `taken_o` is high for exactly that one cycle, and every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_valid_i | input | 1 | Controller has an unmasked vector |
| irq_vec_i | input | 12 | Interrupt vector from controller |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | Current PC |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sleep_i | input | 1 | Core is sleeping |
| imask_o | output | 4 | Current interrupt mask to controller |
| taken_o | output | 1 | One-cycle pulse: event taken |
| evt_irq_o | output | 1 | Last taken event was an interrupt |
| reset_req_o | output | 1 | One-cycle reset request pulse |
| dslot_clr_o | output | 1 | One-cycle pulse: clear delay-slot flag |
| ssr_o | output | 32 | Saved SR |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| sr_o | output | 32 | New SR |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |
| new_pc_o | output | 32 | Entry PC |

## Verification
Every result, including the pulses, the saved registers, the new SR and the new PC, is due at the first rising edge after the stimulus is applied. The pulses fall again one edge later. The bench drives inputs on the falling edge, samples one nanosecond after the next rising edge, then idles the inputs and samples after the following edge to confirm that the pulses have dropped. For ignored events it samples the held outputs at that same first edge and compares them with the values left by the previous scenario. `imask_o` is combinational and is sampled before any edge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN      = 32;
  localparam int CODE_W    = 12;
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_FD_BIT = 15;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;

  typedef enum logic [1:0] {
    TGT_RESET = 2'd0,
    TGT_TLB   = 2'd1,
    TGT_GEN   = 2'd2,
    TGT_IRQ   = 2'd3
  } tgt_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int          CODE_W    = 12,
  parameter logic [11:0] SAFE_CODE = 12'h1E0
) (
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic              bl_i,
  input  logic              sleep_i,
  input  logic              dslot_i,
  output logic              take_exc_o,
  output logic              take_irq_o,
  output logic              rst_req_o
);
  logic irq_open;

  always_comb begin
    rst_req_o  = exc_valid_i && bl_i && (exc_code_i != CODE_W'(SAFE_CODE));
    take_exc_o = exc_valid_i && !rst_req_o;
    // blocked irq stays pending in controller
    irq_open   = !dslot_i && (!bl_i || sleep_i);
    take_irq_o = !exc_valid_i && irq_req_i && irq_vec_valid_i && irq_open;
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int                     XLEN        = 32,
  parameter int                     CODE_W      = 12,
  parameter int                     N_RST_CODES = 3,
  parameter logic [N_RST_CODES*12-1:0] RST_CODES = {12'h000, 12'h020, 12'h140},
  parameter logic [11:0]            TLB_CODE_A  = 12'h040,
  parameter logic [11:0]            TLB_CODE_B  = 12'h060,
  parameter logic [11:0]            TRAP_CODE   = 12'h160,
  parameter logic [31:0]            RESET_PC    = 32'hA000_0000,
  parameter logic [15:0]            OFF_GEN     = 16'h0100,
  parameter logic [15:0]            OFF_TLB     = 16'h0400,
  parameter logic [15:0]            OFF_IRQ     = 16'h0600,
  parameter int                     INSN_BYTES  = 2
) (
  input  logic              take_irq_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   saved_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [N_RST_CODES-1:0] rst_hit;
  logic is_rst, is_tlb, is_trap;
  tgt_e tgt;

  for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst_match
    assign rst_hit[g] = (exc_code_i == CODE_W'(RST_CODES[g*12 +: 12]));
  end

  assign is_rst  = |rst_hit;
  assign is_tlb  = (exc_code_i == CODE_W'(TLB_CODE_A)) || (exc_code_i == CODE_W'(TLB_CODE_B));
  assign is_trap = (exc_code_i == CODE_W'(TRAP_CODE));

  always_comb begin
    if (take_irq_i)  tgt = TGT_IRQ;
    else if (is_rst) tgt = TGT_RESET;
    else if (is_tlb) tgt = TGT_TLB;
    else             tgt = TGT_GEN;
  end

  always_comb begin
    new_sr_o = sr_i;
    new_sr_o[SR_BL_BIT] = 1'b1;
    new_sr_o[SR_MD_BIT] = 1'b1;
    new_sr_o[SR_RB_BIT] = 1'b1;
    case (tgt)
      TGT_RESET: begin
        new_sr_o[SR_FD_BIT] = 1'b0;
        new_sr_o[SR_IM_LSB +: SR_IM_W] = '1;
        new_pc_o = XLEN'(RESET_PC);
      end
      TGT_TLB: new_pc_o = vbr_i + XLEN'(OFF_TLB);
      TGT_IRQ: new_pc_o = vbr_i + XLEN'(OFF_IRQ);
      default: new_pc_o = vbr_i + XLEN'(OFF_GEN);
    endcase
  end

  always_comb begin
    saved_pc_o = pc_i;
    if (dslot_i) saved_pc_o = saved_pc_o - STEP;            // re-run branch
    if (!take_irq_i && is_trap) saved_pc_o = saved_pc_o + STEP;
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter logic [15:0] OFF_IRQ   = 16'h0600,
  parameter logic [11:0] SAFE_CODE = 12'h1E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_exc_i,
  input  logic              take_irq_i,
  input  logic              rst_req_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  input  logic [XLEN-1:0]   new_pc_i,
  input  logic [XLEN-1:0]   new_sr_i,
  input  logic [XLEN-1:0]   saved_pc_i,
  output logic              taken_o,
  output logic              evt_irq_o,
  output logic              reset_req_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [XLEN-1:0]   new_pc_o
);
  logic take;
  assign take = take_exc_i || take_irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o     <= 1'b0;
      evt_irq_o   <= 1'b0;
      reset_req_o <= 1'b0;
      dslot_clr_o <= 1'b0;
      ssr_o       <= '0;
      spc_o       <= '0;
      sgr_o       <= '0;
      sr_o        <= '0;
      expevt_o    <= '0;
      intevt_o    <= '0;
      new_pc_o    <= '0;
    end else begin
      taken_o     <= take;
      reset_req_o <= rst_req_i;
      dslot_clr_o <= take && dslot_i;
      if (take) begin
        evt_irq_o <= take_irq_i;
        ssr_o     <= sr_i;
        spc_o     <= saved_pc_i;
        sgr_o     <= r15_i;
        sr_o      <= new_sr_i;
        new_pc_o  <= new_pc_i;
      end
      if (take_exc_i) expevt_o <= exc_code_i;
      if (take_irq_i) intevt_o <= irq_vec_i;
    end
  end

  assert_exc_priority_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && $past(exc_valid_i)) |-> !evt_irq_o);
  assert_reset_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (!taken_o && $past(sr_i[SR_BL_BIT]) && $past(exc_code_i) != CODE_W'(SAFE_CODE)));
  assert_irq_no_dslot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && evt_irq_o) |-> !$past(dslot_i));
  assert_save_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i)));
  assert_sr_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));
  assert_irq_vector_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && evt_irq_o) |-> (new_pc_o == $past(vbr_i) + XLEN'(OFF_IRQ)));
  assert_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dslot_clr_o |-> taken_o);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = exc_entry_pkg::XLEN,
  parameter int          CODE_W    = exc_entry_pkg::CODE_W,
  parameter logic [11:0] SAFE_CODE = 12'h1E0,
  parameter logic [15:0] OFF_GEN   = 16'h0100,
  parameter logic [15:0] OFF_TLB   = 16'h0400,
  parameter logic [15:0] OFF_IRQ   = 16'h0600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  output logic [SR_IM_W-1:0] imask_o,
  output logic              taken_o,
  output logic              evt_irq_o,
  output logic              reset_req_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [XLEN-1:0]   new_pc_o
);
  logic take_exc, take_irq, rst_req;
  logic [XLEN-1:0] tgt_pc, tgt_sr, tgt_spc;

  assign imask_o = sr_i[SR_IM_LSB +: SR_IM_W];

  exc_arbiter #(.CODE_W(CODE_W), .SAFE_CODE(SAFE_CODE)) u_arb (
    .exc_valid_i    (exc_valid_i),
    .exc_code_i     (exc_code_i),
    .irq_req_i      (irq_req_i),
    .irq_vec_valid_i(irq_vec_valid_i),
    .bl_i           (sr_i[SR_BL_BIT]),
    .sleep_i        (sleep_i),
    .dslot_i        (dslot_i),
    .take_exc_o     (take_exc),
    .take_irq_o     (take_irq),
    .rst_req_o      (rst_req)
  );

  exc_target #(
    .XLEN(XLEN), .CODE_W(CODE_W),
    .OFF_GEN(OFF_GEN), .OFF_TLB(OFF_TLB), .OFF_IRQ(OFF_IRQ)
  ) u_tgt (
    .take_irq_i(take_irq),
    .exc_code_i(exc_code_i),
    .sr_i      (sr_i),
    .pc_i      (pc_i),
    .vbr_i     (vbr_i),
    .dslot_i   (dslot_i),
    .new_pc_o  (tgt_pc),
    .new_sr_o  (tgt_sr),
    .saved_pc_o(tgt_spc)
  );

  exc_regs #(
    .XLEN(XLEN), .CODE_W(CODE_W), .OFF_IRQ(OFF_IRQ), .SAFE_CODE(SAFE_CODE)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_exc_i (take_exc),
    .take_irq_i (take_irq),
    .rst_req_i  (rst_req),
    .exc_valid_i(exc_valid_i),
    .exc_code_i (exc_code_i),
    .irq_vec_i  (irq_vec_i),
    .sr_i       (sr_i),
    .r15_i      (r15_i),
    .vbr_i      (vbr_i),
    .dslot_i    (dslot_i),
    .new_pc_i   (tgt_pc),
    .new_sr_i   (tgt_sr),
    .saved_pc_i (tgt_spc),
    .taken_o    (taken_o),
    .evt_irq_o  (evt_irq_o),
    .reset_req_o(reset_req_o),
    .dslot_clr_o(dslot_clr_o),
    .ssr_o      (ssr_o),
    .spc_o      (spc_o),
    .sgr_o      (sgr_o),
    .sr_o       (sr_o),
    .expevt_o   (expevt_o),
    .intevt_o   (intevt_o),
    .new_pc_o   (new_pc_o)
  );
endmodule

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_v = 0, irq = 0, vv = 0, dslot = 0, sleep = 0;
  logic [11:0] code = '0, vec = '0;
  logic [31:0] sr = '0, pc = '0, r15 = '0, vbr = '0;
  logic [3:0]  imask;
  logic taken, evt_irq, rreq, dclr;
  logic [31:0] ssr, spc, sgr, sr_n, npc;
  logic [11:0] expevt, intevt;
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] PC  = 32'h8C01_0000;
  localparam logic [31:0] R15 = 32'h1234_5678;
  localparam logic [31:0] SRU = 32'h4000_0050; // MD set, mask 5
  localparam logic [31:0] SRB = 32'h5000_0050; // BL also set
  localparam logic [31:0] BLMDRB = 32'h7000_0000;

  always #2.5 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_v), .exc_code_i(code),
    .irq_req_i(irq), .irq_vec_valid_i(vv), .irq_vec_i(vec), .sr_i(sr),
    .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .dslot_i(dslot), .sleep_i(sleep),
    .imask_o(imask), .taken_o(taken), .evt_irq_o(evt_irq), .reset_req_o(rreq),
    .dslot_clr_o(dclr), .ssr_o(ssr), .spc_o(spc), .sgr_o(sgr), .sr_o(sr_n),
    .expevt_o(expevt), .intevt_o(intevt), .new_pc_o(npc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1ns after the next posedge
  task automatic fire(input logic ev, input logic [11:0] c, input logic iq,
                      input logic v, input logic [11:0] vc, input logic [31:0] s,
                      input logic ds, input logic sl);
    @(negedge clk);
    exc_v = ev; code = c; irq = iq; vv = v; vec = vc; sr = s; dslot = ds; sleep = sl;
    pc = PC; r15 = R15; vbr = VBR;
    @(posedge clk); #1;
  endtask

  task automatic idle_and_check_drop(input string req);
    @(negedge clk);
    exc_v = 0; irq = 0; vv = 0; dslot = 0; sleep = 0;
    @(posedge clk); #1;
    chk(req, {29'd0, taken, rreq, dclr}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R13", {29'd0, taken, rreq, dclr}, 32'd0);
    chk("R13", npc, 32'd0);
    chk("R13", {20'd0, expevt}, 32'd0);
    chk("R13", sr_n, 32'd0);
  endtask

  task automatic t_general;
    @(negedge clk); sr = SRU; #1;
    chk("R5", {28'd0, imask}, 32'd5);
    fire(1, 12'h180, 0, 0, 0, SRU, 0, 0);
    chk("R13", {31'd0, taken}, 32'd1);
    chk("R11", npc, VBR + 32'h100);
    chk("R8", spc, PC);
    chk("R8", {31'd0, dclr}, 32'd0);
    chk("R7", ssr, SRU);
    chk("R7", sgr, R15);
    chk("R7", sr_n, SRU | BLMDRB);
    chk("R11", {20'd0, expevt}, 32'h180);
    idle_and_check_drop("R13");
  endtask

  task automatic t_trapa;
    fire(1, 12'h160, 0, 0, 0, SRU, 0, 0);
    chk("R11", spc, PC + 32'd2);
    chk("R11", npc, VBR + 32'h100);
    idle_and_check_drop("R13");
  endtask

  task automatic t_tlb;
    fire(1, 12'h040, 0, 0, 0, SRU, 0, 0);
    chk("R10", npc, VBR + 32'h400);
    idle_and_check_drop("R13");
    fire(1, 12'h060, 0, 0, 0, SRU, 0, 0);
    chk("R10", npc, VBR + 32'h400);
    chk("R10", {20'd0, expevt}, 32'h060);
    idle_and_check_drop("R13");
  endtask

  task automatic t_reset_class;
    logic [31:0] s;
    s = 32'h4000_8030;
    fire(1, 12'h140, 0, 0, 0, s, 0, 0);
    chk("R9", npc, 32'hA000_0000);
    chk("R9", sr_n, 32'h7000_00F0);
    idle_and_check_drop("R13");
    fire(1, 12'h000, 0, 0, 0, s, 0, 0);
    chk("R9", npc, 32'hA000_0000);
    idle_and_check_drop("R13");
    fire(1, 12'h020, 0, 0, 0, s, 0, 0);
    chk("R9", sr_n, 32'h7000_00F0);
    idle_and_check_drop("R13");
  endtask

  task automatic t_dslot;
    fire(1, 12'h180, 0, 0, 0, SRU, 1, 0);
    chk("R8", spc, PC - 32'd2);
    chk("R8", {31'd0, dclr}, 32'd1);
    idle_and_check_drop("R8");
  endtask

  task automatic t_irq;
    fire(0, 0, 1, 1, 12'h320, SRU, 0, 0);
    chk("R12", {30'd0, taken, evt_irq}, 32'd3);
    chk("R12", {20'd0, intevt}, 32'h320);
    chk("R12", npc, VBR + 32'h600);
    chk("R12", {20'd0, expevt}, 32'h020);
    idle_and_check_drop("R13");
  endtask

  task automatic t_priority;
    fire(1, 12'h0E0, 1, 1, 12'h5A0, SRU, 0, 0);
    chk("R1", {31'd0, evt_irq}, 32'd0);
    chk("R1", {20'd0, expevt}, 32'h0E0);
    chk("R1", {20'd0, intevt}, 32'h320);
    idle_and_check_drop("R13");
  endtask

  task automatic t_irq_blocked;
    fire(0, 0, 1, 0, 12'h400, SRU, 0, 0);
    chk("R5", {31'd0, taken}, 32'd0);
    chk("R5", npc, VBR + 32'h100);
    idle_and_check_drop("R5");
    fire(0, 0, 1, 1, 12'h400, SRU, 1, 0);
    chk("R6", {31'd0, taken}, 32'd0);
    chk("R6", {20'd0, intevt}, 32'h320);
    idle_and_check_drop("R6");
    fire(0, 0, 1, 1, 12'h400, SRB, 0, 0);
    chk("R4", {31'd0, taken}, 32'd0);
    chk("R4", {20'd0, intevt}, 32'h320);
    idle_and_check_drop("R4");
    fire(0, 0, 1, 1, 12'h400, SRB, 0, 1);
    chk("R4", {31'd0, taken}, 32'd1);
    chk("R4", {20'd0, intevt}, 32'h400);
    idle_and_check_drop("R4");
  endtask

  task automatic t_bl_exc;
    fire(1, 12'h180, 0, 0, 0, SRB, 0, 0);
    chk("R2", {30'd0, rreq, taken}, 32'd2);
    chk("R2", npc, VBR + 32'h600);
    chk("R2", {20'd0, expevt}, 32'h0E0);
    idle_and_check_drop("R2");
    fire(1, 12'h1E0, 0, 0, 0, SRB, 0, 0);
    chk("R3", {30'd0, rreq, taken}, 32'd1);
    chk("R3", npc, VBR + 32'h100);
    chk("R3", {20'd0, expevt}, 32'h1E0);
    idle_and_check_drop("R3");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_general;
    t_trapa;
    t_tlb;
    t_dslot;
    t_reset_class;
    t_irq;
    t_priority;
    t_irq_blocked;
    t_bl_exc;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule